// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block accumulates occurrences of an event that can fire several times in one clock cycle. Each cycle it receives a small count of that cycle's occurrences and decides whether to add it. The count passes a programmable test against a 12-bit threshold, and the accumulator moves only on cycles where the test succeeds. On a passing cycle the accumulator adds either the cycle's count or exactly one, depending on a configuration flag. A threshold of zero turns the test off, and then every cycle's count is added.

Software programs the threshold, the relation and the add-one flag in a single write. The block publishes the largest threshold it supports as a constant capability output. A write whose threshold exceeds that capability is refused: the settings already held stay as they are, and a sticky error flag is raised until software clears it. If the block is built with a capability of zero, thresholding is absent, so every nonzero threshold is refused and counts always pass through unqualified. The accumulator value is always visible and can be cleared with a one-cycle pulse.

Top module: `thr_evt_counter`

## Requirements
- R1: After reset the accumulator is 0, the held threshold is 0, the held relation code is 0, the add-one flag is 0 and the error flag is 0.
- R2: While the held threshold is 0, each clock adds that cycle's event count to the accumulator, whatever the relation code and add-one flag hold.
- R3: The relation code selects the test between the zero-extended event count (left) and the threshold (right): 0 means not-equal, 1 means equal, 2 means greater-than-or-equal, 3 means less-than.
- R4: With a nonzero threshold and add-one clear, a cycle whose count passes the test adds that count, and a cycle that fails adds 0.
- R5: With a nonzero threshold and add-one set, a passing cycle adds exactly 1, even when its count is 0, and a failing cycle adds 0.
- R6: The capability output is the constant largest supported threshold (255 by default, never above 4095).
- R7: A configuration write whose threshold is above the capability changes none of the held settings and sets the error flag on the next clock.
- R8: The error flag stays set until an error-clear pulse. When a refused write and an error clear occur in the same cycle, the flag stays set.
- R9: An accumulator-clear pulse makes the accumulator 0 on the next clock, and that cycle's event count is discarded.
- R10: An accepted configuration write is visible on the settings outputs after the next clock. It governs events from that cycle on, so the event in the write cycle is judged under the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cnt | input | 4 | Occurrences of the event in this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr | input | 12 | Threshold to write |
| cfg_rel | input | 2 | Relation code to write |
| cfg_one | input | 1 | Add-one flag to write |
| err_clr | input | 1 | Clears the error flag |
| acc_clr | input | 1 | Clears the accumulator |
| acc_val | output | 48 | Accumulator value |
| cur_thr | output | 12 | Held threshold |
| cur_rel | output | 2 | Held relation code |
| cur_one | output | 1 | Held add-one flag |
| cfg_err | output | 1 | Sticky refused-write flag |
| thr_cap | output | 12 | Largest supported threshold |

## Verification
The bench drives every event count from 0 to 15 against a threshold of 5 under each relation code. This catches a design that swaps equal and not-equal, or that treats the ge test as strict, because the accumulator would then drift at the count equal to the threshold. It writes thresholds of 255 and 256 to probe the capability edge: a design that compares with >= would refuse a legal value, and one that lets a refused write through would change the settings outputs. Further directed cases cover add-one on a passing zero count, clear against a live event, and error clear racing a refused write. Seeded random configuration and event traffic follows, so that mistakes in ordering between a write and the events around it show up as accumulator drift.

// File: rtl/thrc_pkg.sv
package thrc_pkg;
   typedef enum logic [1:0] {
      REL_NE = 2'd0,
      REL_EQ = 2'd1,
      REL_GE = 2'd2,
      REL_LT = 2'd3
   } rel_e;

   localparam int unsigned THR_FIELD_W = 12;
endpackage

// File: rtl/thrc_cfg.sv
module thrc_cfg #(
   parameter int unsigned THR_W   = 12,
   parameter int unsigned THR_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [THR_W-1:0] thr_in,
   input  logic [1:0]       rel_in,
   input  logic             one_in,
   input  logic             err_clr,
   output logic [THR_W-1:0] thr_q,
   output logic [1:0]       rel_q,
   output logic             one_q,
   output logic             err_q
);
   localparam logic [THR_W-1:0] CAP = THR_W'(THR_MAX);

   logic refuse;
   logic accept;

   always_comb begin
      refuse = we && (thr_in > CAP);
      accept = we && !refuse;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= '0;
         rel_q <= 2'd0;
         one_q <= 1'b0;
      end else if (accept) begin
         thr_q <= thr_in;
         rel_q <= rel_in;
         one_q <= one_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (refuse)
         err_q <= 1'b1;
      else if (err_clr)
         err_q <= 1'b0;
   end
endmodule

// File: rtl/thrc_qual.sv
module thrc_qual
   import thrc_pkg::*;
#(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned THR_W   = 12,
   parameter int unsigned THR_MAX = 255
) (
   input  logic [CNT_W-1:0] evt,
   input  logic [THR_W-1:0] thr,
   input  logic [1:0]       rel,
   input  logic             one,
   output logic [CNT_W-1:0] inc
);
   generate
      if (THR_MAX == 0) begin : g_plain
         logic unused_cfg;
         assign unused_cfg = ^{thr, rel, one};
         assign inc = evt;
      end else begin : g_thresh
         logic [THR_W-1:0] evt_ext;
         logic             pass;

         always_comb begin
            evt_ext = THR_W'(evt);
            unique case (rel_e'(rel))
               REL_NE:  pass = (evt_ext != thr);
               REL_EQ:  pass = (evt_ext == thr);
               REL_GE:  pass = (evt_ext >= thr);
               default: pass = (evt_ext <  thr);
            endcase
            if (thr == '0)
               inc = evt;
            else if (!pass)
               inc = '0;
            else if (one)
               inc = CNT_W'(1);
            else
               inc = evt;
         end
      end
   endgenerate
endmodule

// File: rtl/thrc_acc.sv
module thrc_acc #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] inc,
   output logic [ACC_W-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else
         acc <= acc + ACC_W'(inc);
   end
endmodule

// File: rtl/thr_evt_counter.sv
module thr_evt_counter #(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned THR_W   = thrc_pkg::THR_FIELD_W,
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned THR_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] evt_cnt,
   input  logic             cfg_we,
   input  logic [THR_W-1:0] cfg_thr,
   input  logic [1:0]       cfg_rel,
   input  logic             cfg_one,
   input  logic             err_clr,
   input  logic             acc_clr,
   output logic [ACC_W-1:0] acc_val,
   output logic [THR_W-1:0] cur_thr,
   output logic [1:0]       cur_rel,
   output logic             cur_one,
   output logic             cfg_err,
   output logic [THR_W-1:0] thr_cap
);
   localparam int unsigned FIELD_LIMIT = (1 << THR_W) - 1;

   generate
      if (THR_MAX > FIELD_LIMIT) begin : g_bad_cap
         $error("THR_MAX does not fit the threshold field");
      end
      if (THR_W < CNT_W) begin : g_bad_width
         $error("threshold field narrower than event count");
      end
      if (ACC_W <= CNT_W) begin : g_bad_acc
         $error("accumulator must be wider than event count");
      end
   endgenerate

   logic [CNT_W-1:0] inc;

   assign thr_cap = THR_W'(THR_MAX);

   thrc_cfg #(.THR_W(THR_W), .THR_MAX(THR_MAX)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .thr_in  (cfg_thr),
      .rel_in  (cfg_rel),
      .one_in  (cfg_one),
      .err_clr (err_clr),
      .thr_q   (cur_thr),
      .rel_q   (cur_rel),
      .one_q   (cur_one),
      .err_q   (cfg_err)
   );

   thrc_qual #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_MAX(THR_MAX)) u_qual (
      .evt (evt_cnt),
      .thr (cur_thr),
      .rel (cur_rel),
      .one (cur_one),
      .inc (inc)
   );

   thrc_acc #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .inc   (inc),
      .acc   (acc_val)
   );
endmodule

// File: rtl/thr_evt_counter_chk.sv
module thr_evt_counter_chk #(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned THR_W   = 12,
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned THR_MAX = 255
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] evt_cnt,
   input logic             cfg_we,
   input logic [THR_W-1:0] cfg_thr,
   input logic             err_clr,
   input logic             acc_clr,
   input logic [ACC_W-1:0] acc_val,
   input logic [THR_W-1:0] cur_thr,
   input logic             cur_one,
   input logic             cfg_err,
   input logic [THR_W-1:0] thr_cap
);
   localparam logic [ACC_W-1:0] MAX_STEP = ACC_W'((1 << CNT_W) - 1);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc_val == '0));

   p_raw_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && cur_thr == '0) |=>
         (acc_val == $past(acc_val) + ACC_W'($past(evt_cnt))));

   p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_clr |=> ((acc_val - $past(acc_val)) <= MAX_STEP));

   p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && cur_thr != '0 && cur_one) |=>
         ((acc_val - $past(acc_val)) <= ACC_W'(1)));

   p_cap_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(thr_cap) && (thr_cap == THR_W'(THR_MAX)));

   p_thr_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_thr <= thr_cap);

   p_refuse_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_thr > thr_cap) |=> ($stable(cur_thr) && cfg_err));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !err_clr) |=> cfg_err);
endmodule

bind thr_evt_counter thr_evt_counter_chk #(
   .CNT_W(CNT_W), .THR_W(THR_W), .ACC_W(ACC_W), .THR_MAX(THR_MAX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_cnt (evt_cnt),
   .cfg_we  (cfg_we),
   .cfg_thr (cfg_thr),
   .err_clr (err_clr),
   .acc_clr (acc_clr),
   .acc_val (acc_val),
   .cur_thr (cur_thr),
   .cur_one (cur_one),
   .cfg_err (cfg_err),
   .thr_cap (thr_cap)
);

// File: tb/thr_evt_counter_bench.sv
module thr_evt_counter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CAP = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt_cnt = '0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_thr = '0;
   logic [1:0]  cfg_rel = '0;
   logic        cfg_one = 1'b0;
   logic        err_clr = 1'b0;
   logic        acc_clr = 1'b0;
   logic [47:0] acc_val;
   logic [11:0] cur_thr;
   logic [1:0]  cur_rel;
   logic        cur_one;
   logic        cfg_err;
   logic [11:0] thr_cap;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [47:0] m_acc;
   logic [11:0] m_thr;
   logic [1:0]  m_rel;
   logic        m_one;
   logic        m_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_evt_counter u_thr_evt_counter (
      .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .cfg_we(cfg_we),
      .cfg_thr(cfg_thr), .cfg_rel(cfg_rel), .cfg_one(cfg_one),
      .err_clr(err_clr), .acc_clr(acc_clr), .acc_val(acc_val),
      .cur_thr(cur_thr), .cur_rel(cur_rel), .cur_one(cur_one),
      .cfg_err(cfg_err), .thr_cap(thr_cap)
   );

   function automatic logic [3:0] exp_inc(logic [3:0] e, logic [11:0] t,
                                          logic [1:0] r, logic o);
      logic [11:0] x;
      logic ok;
      x = {8'd0, e};
      case (r)
         2'd0: ok = (x != t);
         2'd1: ok = (x == t);
         2'd2: ok = (x >= t);
         default: ok = (x < t);
      endcase
      if (t == 12'd0) return e;
      if (!ok) return 4'd0;
      return o ? 4'd1 : e;
   endfunction

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(string req, logic [3:0] e, logic we, logic [11:0] t,
                      logic [1:0] r, logic o, logic ec, logic ac);
      logic [47:0] n_acc;
      evt_cnt = e; cfg_we = we; cfg_thr = t; cfg_rel = r; cfg_one = o;
      err_clr = ec; acc_clr = ac;
      n_acc = ac ? 48'd0 : m_acc + 48'(exp_inc(e, m_thr, m_rel, m_one));
      if (we && t > 12'(CAP)) m_err = 1'b1;
      else begin
         if (ec) m_err = 1'b0;
         if (we) begin m_thr = t; m_rel = r; m_one = o; end
      end
      m_acc = n_acc;
      @(posedge clk);
      @(negedge clk);
      evt_cnt = '0; cfg_we = 1'b0; err_clr = 1'b0; acc_clr = 1'b0;
      chk(req, acc_val, m_acc);
      chk(req, {36'd0, cur_thr}, {36'd0, m_thr});
      chk(req, {46'd0, cur_rel}, {46'd0, m_rel});
      chk(req, {47'd0, cur_one}, {47'd0, m_one});
      chk(req, {47'd0, cfg_err}, {47'd0, m_err});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240108));
      m_acc = '0; m_thr = '0; m_rel = '0; m_one = 1'b0; m_err = 1'b0;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      // R1 reset state, R6 capability
      chk("R1", acc_val, 48'd0);
      chk("R1", {36'd0, cur_thr}, 48'd0);
      chk("R1", {46'd0, cur_rel}, 48'd0);
      chk("R1", {47'd0, cur_one}, 48'd0);
      chk("R1", {47'd0, cfg_err}, 48'd0);
      chk("R6", {36'd0, thr_cap}, 48'(CAP));
      rst_n = 1'b1;
      @(negedge clk);

      // R2 threshold zero ignores relation and add-one
      cyc("R2", 4'd0, 1'b1, 12'd0, 2'd3, 1'b1, 1'b0, 1'b0);
      cyc("R2", 4'd7, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R2", 4'd15, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);

      // R3 / R4 each relation against threshold 5, all counts
      for (int r = 0; r < 4; r++) begin
         cyc("R3", 4'd0, 1'b1, 12'd5, 2'(r), 1'b0, 1'b0, 1'b1);
         for (int e = 0; e < 16; e++)
            cyc("R4", 4'(e), 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      end

      // R5 add-one, incl. passing zero count with less-than
      cyc("R5", 4'd9, 1'b1, 12'd3, 2'd3, 1'b1, 1'b0, 1'b1);
      cyc("R5", 4'd0, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R5", 4'd2, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R5", 4'd3, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R5", 4'd14, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);

      // R7 capability edge: 255 accepted, 256 refused
      cyc("R7", 4'd1, 1'b1, 12'd255, 2'd1, 1'b0, 1'b0, 1'b0);
      cyc("R7", 4'd15, 1'b1, 12'd256, 2'd2, 1'b1, 1'b0, 1'b0);
      cyc("R7", 4'd15, 1'b1, 12'd4095, 2'd0, 1'b1, 1'b0, 1'b0);
      // R8 sticky, clear, race
      cyc("R8", 4'd3, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R8", 4'd3, 1'b0, 12'd0, 2'd0, 1'b0, 1'b1, 1'b0);
      cyc("R8", 4'd3, 1'b1, 12'd300, 2'd0, 1'b0, 1'b1, 1'b0);
      cyc("R8", 4'd3, 1'b0, 12'd0, 2'd0, 1'b0, 1'b1, 1'b0);

      // R9 clear discards live event
      cyc("R9", 4'd0, 1'b1, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R9", 4'd8, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R9", 4'd12, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b1);

      // R10 event in write cycle judged under old settings
      cyc("R10", 4'd6, 1'b1, 12'd10, 2'd2, 1'b0, 1'b0, 1'b0);
      cyc("R10", 4'd6, 1'b1, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);
      cyc("R10", 4'd6, 1'b0, 12'd0, 2'd0, 1'b0, 1'b0, 1'b0);

      // seeded random traffic (R4 accumulation)
      for (int i = 0; i < 3000; i++) begin
         logic we;
         logic [11:0] t;
         we = ($urandom % 8) == 0;
         case ($urandom % 3)
            0: t = 12'($urandom % 16);
            1: t = 12'($urandom % 300);
            default: t = 12'($urandom);
         endcase
         cyc("R4", 4'($urandom), we, t, 2'($urandom), 1'($urandom),
             ($urandom % 16) == 0, ($urandom % 64) == 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule